// File: doc/BRIEF.md
# Timer Capture/Compare Pin Controller

This unit couples one general-purpose timer register with one timer I/O pin. A free-running counter value comes in from outside the unit, and a 4-bit mode code decides what the unit does with it.

In compare modes the unit compares the counter with the register. The pin is either disabled, or it is first forced to a programmed starting level. After that, each match drives the pin low, drives it high or inverts it.

In capture modes the unit copies the counter into the register when the pin shows a chosen edge. One group of codes ignores the pin and captures when a strobe arrives from a neighbouring channel's match or capture event.

Every match or capture raises a one-cycle event flag. Software reaches the register through a simple write port. The mode code is loaded through its own write strobe.

Top module: `tmr_pin_unit`

## Requirements
- R1: After reset the mode code is 4'b0000, and pin_oe, pin_out, reg_val and evt_flag are all 0.
- R2: Codes 4'b0000 and 4'b0100 keep the register in compare use with pin_oe low and pin_out unchanged; matches still pulse evt_flag.
- R3: Writing a code with bit 3 = 0 and bits [1:0] != 0 sets pin_out to code bit 2 and raises pin_oe on the next cycle, before any match.
- R4: In codes with bit 3 = 0, a match is cnt_val == reg_val. On a match, bits [1:0] select the pin action visible one cycle later: 01 drives 0, 10 drives 1, 11 toggles.
- R5: evt_flag is high in the cycle after each cycle that has a match or a capture, and low otherwise.
- R6: pin_in passes through two synchronizing flops. A capture on a pin edge loads reg_val on the third rising clock edge after the pin changes, and a single edge gives exactly one capture.
- R7: Code 4'b1000 captures on rising pin edges, 4'b1001 on falling edges, and 4'b1010 and 4'b1011 on both edges.
- R8: Codes 4'b11xx ignore the pin. They load cnt_val into the register one cycle after a cycle with casc_evt high.
- R9: A capture wins over a register write in the same cycle. With no capture, a write loads reg_wd on the next cycle.
- R10: In codes with bit 3 = 1, pin_oe is low, and cnt_val == reg_val neither flags nor changes pin_out.

Top module ports and their order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Free-running counter value |
| mode_we | input | 1 | Load strobe for the mode code |
| mode_wd | input | 4 | New mode code |
| reg_we | input | 1 | Register write strobe |
| reg_wd | input | CNT_W | Register write data |
| pin_in | input | 1 | Asynchronous pin input level |
| casc_evt | input | 1 | Match/capture strobe from the neighbouring channel |
| pin_out | output | 1 | Driven pin level |
| pin_oe | output | 1 | Pin output enable |
| reg_val | output | CNT_W | Current register contents |
| evt_flag | output | 1 | One-cycle match/capture pulse |

## Verification
Some behaviours are checked by assertions on every cycle:
- the flag follows each match or capture event;
- a capture loads the counter and overrides a same-cycle write;
- the starting level follows a mode write;
- a toggle action inverts the pin;
- the pin holds while disabled;
- capture modes raise no compare match and the cascade codes ignore the pin.

Other behaviours can only be shown by the bench's sweep over all sixteen codes, observed at the ports:
- the three-edge latency through the synchronizer;
- which edge each capture code reacts to;
- that one edge gives a single capture.

// File: rtl/tmr_pin_pkg.sv
package tmr_pin_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  // bit 3 set selects capture use of the register
  function automatic logic is_capture_mode(input logic [3:0] m);
    return m[3];
  endfunction

  // compare use with a non-zero action field drives the pin
  function automatic logic drives_pin(input logic [3:0] m);
    return !m[3] && (m[1:0] != 2'b00);
  endfunction

  function automatic logic start_level(input logic [3:0] m);
    return m[2];
  endfunction

  function automatic pin_act_e match_action(input logic [3:0] m);
    if (m[3]) return ACT_KEEP;
    return pin_act_e'(m[1:0]);
  endfunction

  function automatic logic apply_action(input pin_act_e a, input logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  function automatic logic capture_fire(input logic [3:0] m, input logic rise,
                                        input logic fall, input logic casc);
    if (m[3:2] == 2'b11) return casc;
    if (!m[3]) return 1'b0;
    if (m[1]) return rise | fall;
    return m[0] ? fall : rise;
  endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_rise,
  output logic pin_fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAST-1:0], pin_in};
  end

  // sh[LAST-1] is the synchronized level, sh[LAST] the prior sample
  assign pin_rise =  sh[LAST-1] & ~sh[LAST];
  assign pin_fall = ~sh[LAST-1] &  sh[LAST];
endmodule

// File: rtl/tmr_pin_out.sv
module tmr_pin_out
  import tmr_pin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_q,
  input  logic       mode_we,
  input  logic [3:0] mode_wd,
  input  logic       cmp_hit,
  output logic       pin_lvl,
  output logic       pin_en
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      lvl_q <= 1'b0;
    else if (mode_we && drives_pin(mode_wd))
      lvl_q <= start_level(mode_wd);
    else if (cmp_hit && drives_pin(mode_q))
      lvl_q <= apply_action(match_action(mode_q), lvl_q);
  end

  assign pin_lvl = lvl_q;
  assign pin_en  = drives_pin(mode_q);
endmodule

// File: rtl/tmr_pin_greg.sv
module tmr_pin_greg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             reg_we,
  input  logic [CNT_W-1:0] reg_wd,
  output logic [CNT_W-1:0] reg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       reg_q <= '0;
    else if (cap_evt) reg_q <= cnt_val;
    else if (reg_we)  reg_q <= reg_wd;
  end
endmodule

// File: rtl/tmr_pin_unit.sv
module tmr_pin_unit
  import tmr_pin_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             mode_we,
  input  logic [3:0]       mode_wd,
  input  logic             reg_we,
  input  logic [CNT_W-1:0] reg_wd,
  input  logic             pin_in,
  input  logic             casc_evt,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [CNT_W-1:0] reg_val,
  output logic             evt_flag
);
  logic [3:0] mode_q;
  logic       pin_rise;
  logic       pin_fall;
  logic       cmp_hit;
  logic       cap_evt;
  logic       flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= 4'b0000;
    else if (mode_we) mode_q <= mode_wd;
  end

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .pin_rise (pin_rise),
    .pin_fall (pin_fall)
  );

  assign cmp_hit = !is_capture_mode(mode_q) && (cnt_val == reg_val);
  assign cap_evt = capture_fire(mode_q, pin_rise, pin_fall, casc_evt);

  tmr_pin_greg #(.CNT_W(CNT_W)) u_greg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_evt (cap_evt),
    .cnt_val (cnt_val),
    .reg_we  (reg_we),
    .reg_wd  (reg_wd),
    .reg_q   (reg_val)
  );

  tmr_pin_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .mode_we (mode_we),
    .mode_wd (mode_wd),
    .cmp_hit (cmp_hit),
    .pin_lvl (pin_out),
    .pin_en  (pin_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= cmp_hit | cap_evt;
  end

  assign evt_flag = flag_q;
endmodule

// File: rtl/tmr_pin_unit_chk.sv
module tmr_pin_unit_chk
  import tmr_pin_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             mode_we,
  input logic [3:0]       mode_wd,
  input logic             reg_we,
  input logic [CNT_W-1:0] reg_wd,
  input logic             casc_evt,
  input logic             pin_out,
  input logic             pin_oe,
  input logic [CNT_W-1:0] reg_val,
  input logic             evt_flag,
  input logic [3:0]       mode_q,
  input logic             cmp_hit,
  input logic             cap_evt
);
  // R5
  flag_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit || cap_evt) |=> evt_flag);

  // R5
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_hit && !cap_evt) |=> !evt_flag);

  // R9
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (reg_val == $past(cnt_val)));

  // R9
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !cap_evt) |=> (reg_val == $past(reg_wd)));

  // R3
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && drives_pin(mode_wd)) |=> (pin_oe && pin_out == $past(mode_wd[2])));

  // R4
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && cmp_hit && !mode_we && mode_q[1:0] == 2'b11) |=> (pin_out != $past(pin_out)));

  // R2
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_oe && !mode_we) |=> $stable(pin_out));

  // R10
  capture_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[3] |-> (!cmp_hit && !pin_oe));

  // R8
  casc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'b11 && !casc_evt) |-> !cap_evt);
endmodule

bind tmr_pin_unit tmr_pin_unit_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tmr_pin_unit_bench.sv
`timescale 1ns/1ps
module tmr_pin_unit_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt_val;
  logic         mode_we;
  logic [3:0]   mode_wd;
  logic         reg_we;
  logic [W-1:0] reg_wd;
  logic         pin_in;
  logic         casc_evt;
  logic         pin_out;
  logic         pin_oe;
  logic [W-1:0] reg_val;
  logic         evt_flag;

  int n_chk = 0;
  int n_err = 0;
  logic exp_pin;
  logic [W-1:0] exp_reg;

  always #10 clk = ~clk;

  tmr_pin_unit u_tmr_pin_unit (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .mode_we(mode_we),
    .mode_wd(mode_wd), .reg_we(reg_we), .reg_wd(reg_wd), .pin_in(pin_in),
    .casc_evt(casc_evt), .pin_out(pin_out), .pin_oe(pin_oe),
    .reg_val(reg_val), .evt_flag(evt_flag)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Arithmetic view of the mode code: code < 8 is compare use, code % 4 is the action
  function automatic logic code_drives(input int c);
    return (c < 8) && (c % 4 != 0);
  endfunction

  function automatic logic after_match(input int c, input logic cur);
    case (c % 4)
      1:       return 1'b0;
      2:       return 1'b1;
      3:       return !cur;
      default: return cur;
    endcase
  endfunction

  task automatic run_code(input int c);
    logic want_r;
    logic want_f;
    want_r = (c == 8) || (c == 10) || (c == 11);
    want_f = (c == 9) || (c == 10) || (c == 11);

    reg_we = 1'b1; reg_wd = 16'd40; step(); reg_we = 1'b0;
    exp_reg = 16'd40;
    check("R9", "register write", reg_val, exp_reg);

    mode_we = 1'b1; mode_wd = c[3:0]; step(); mode_we = 1'b0;
    if (code_drives(c)) exp_pin = (c / 4) % 2 == 1;
    check(code_drives(c) ? "R3" : "R2", "pin level after mode write", pin_out, exp_pin);
    check(c >= 8 ? "R10" : "R3", "output enable", pin_oe, code_drives(c));

    if (c < 8) begin
      for (int k = 0; k < 2; k++) begin
        cnt_val = 16'd39; step();
        check("R5", "no flag without match", evt_flag, 0);
        cnt_val = 16'd40; step();
        exp_pin = after_match(c, exp_pin);
        check(code_drives(c) ? "R4" : "R2", "pin after match", pin_out, exp_pin);
        check("R5", "flag on match", evt_flag, 1);
        cnt_val = 16'd1000; step();
        check("R5", "flag is one cycle", evt_flag, 0);
      end
    end else begin
      cnt_val = 16'd40; step();
      check("R10", "no compare flag in capture use", evt_flag, 0);
      check("R10", "pin held in capture use", pin_out, exp_pin);

      cnt_val = 16'd100; pin_in = 1'b1; step(); step();
      check("R6", "no capture before third edge", reg_val, exp_reg);
      step();
      if (want_r) exp_reg = 16'd100;
      check(c >= 12 ? "R8" : "R7", "rising edge capture", reg_val, exp_reg);
      check("R5", "flag on rising capture", evt_flag, want_r);
      step();
      check("R6", "single capture per edge", evt_flag, 0);

      cnt_val = 16'd200; pin_in = 1'b0; step(); step(); step();
      if (want_f) exp_reg = 16'd200;
      check(c >= 12 ? "R8" : "R7", "falling edge capture", reg_val, exp_reg);
      check("R5", "flag on falling capture", evt_flag, want_f);
      step();

      if (c >= 12) begin
        cnt_val = 16'd300; casc_evt = 1'b1; step(); casc_evt = 1'b0;
        exp_reg = 16'd300;
        check("R8", "cascade capture", reg_val, exp_reg);
        check("R8", "cascade flag", evt_flag, 1);
        step();
        check("R5", "cascade flag is one cycle", evt_flag, 0);
      end
      cnt_val = 16'd1000;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_val = 16'd1000; mode_we = 1'b0; mode_wd = 4'd0;
    reg_we = 1'b0; reg_wd = '0; pin_in = 1'b0; casc_evt = 1'b0;
    exp_pin = 1'b0; exp_reg = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1", "reset pin_oe", pin_oe, 0);
    check("R1", "reset pin_out", pin_out, 0);
    check("R1", "reset reg_val", reg_val, 0);
    check("R1", "reset evt_flag", evt_flag, 0);

    for (int c = 0; c < 16; c++) run_code(c);

    cnt_val = 16'd500; casc_evt = 1'b1; reg_we = 1'b1; reg_wd = 16'd77;
    step();
    casc_evt = 1'b0; reg_we = 1'b0;
    check("R9", "capture beats write", reg_val, 500);
    reg_we = 1'b1; step(); reg_we = 1'b0;
    check("R9", "write without capture", reg_val, 77);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule